// File: doc/BRIEF.md
# Same-Line Request Merger

This block sits between a group of load/store units and a single-ported L1 data array. Each unit owns two request slots, because an access that crosses a 16-byte boundary is split upstream into two line-sized halves. A slot presents a line address, a 16-bit byte-enable mask with one bit per byte column of the line, a load/store flag and 128 bits of store data. Slot `s` belongs to unit `s/2`, half `s%2`. With the default parameters there are 6 units and 12 slots.

Each cycle the block chooses one leading slot with a rotating pointer. It grants that slot and every other eligible slot that targets the same line with the same operation type. The granted masks are OR-ed into one L1 access, so several units are served by a single array cycle. The array does either a read or a write in a cycle, never both, so loads and stores are never mixed in one access. Overlapping store bytes are resolved in favour of the highest-numbered slot.

The L1 access and the grant vector are registered and appear one cycle after the request is sampled. A unit keeps its request up until it sees its grant. In the cycle its grant is shown, the slot is ignored, so the unit may replace or drop the request then. Load data from the array comes back one cycle after the access is presented. It is broadcast with a valid vector marking every slot that the load served.

Top module: `same_line_merger`

## Requirements
- R1: While `rst` is high at a rising edge, `l1_valid`, `grant`, all L1 access fields and the pointer are cleared. The pointer restarts at slot 0. `rsp_valid` is zero while `l1_rvalid` is low.
- R2: The leading slot is the first eligible slot at or after the pointer, searching upward and wrapping past the last slot. After each access the pointer moves to the slot after the leader, wrapping to 0.
- R3: A slot is granted exactly when it is eligible and matches the leader in both line address and load/store flag (`req_store`: 1 = store, 0 = load). Slots that differ in either are not granted that cycle.
- R4: `l1_line` equals the leader's line and `l1_store` equals the leader's flag. `l1_mask` is the OR of the masks of all granted slots, where mask bit b enables byte b of the line.
- R5: Byte b of `l1_wdata` (bits 8b+7..8b) comes from the highest-numbered granted slot whose mask bit b is set. It is zero if no granted mask sets bit b.
- R6: At most one L1 access is issued per cycle. `l1_valid` is high exactly when `grant` is non-zero, and both appear in the cycle after the sampled requests.
- R7: A slot whose grant is being shown is not eligible in that cycle, whatever it presents. Valid slots that are not granted stay eligible in later cycles.
- R8: When `l1_rvalid` is high, `rsp_valid` equals the grant vector of the load access that was shown in the previous cycle, and `rsp_data` equals `l1_rdata`. If that access was a store or there was none, `rsp_valid` is zero.
- R9: With no eligible slot, `l1_valid`, `grant`, `l1_line`, `l1_store`, `l1_mask` and `l1_wdata` are zero and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Per-slot request present |
| req_store | input | NREQ | Per-slot flag, 1 = store, 0 = load |
| req_line | input | NREQ*LINE_AW | Per-slot line address, slot s at bits s*LINE_AW upward |
| req_mask | input | NREQ*LINE_BYTES | Per-slot byte enables, slot s at bits s*LINE_BYTES upward |
| req_wdata | input | NREQ*LINE_BYTES*8 | Per-slot store data, byte b of the line in bits 8b+7..8b |
| l1_valid | output | 1 | L1 access present |
| l1_store | output | 1 | L1 access is a write |
| l1_line | output | LINE_AW | L1 line address |
| l1_mask | output | LINE_BYTES | Merged byte enables |
| l1_wdata | output | LINE_BYTES*8 | Merged write data |
| l1_rdata | input | LINE_BYTES*8 | Read data from the array |
| l1_rvalid | input | 1 | Read data valid, one cycle after the load access is shown |
| grant | output | NREQ | Slots served by the access now shown |
| rsp_valid | output | NREQ | Slots that receive `rsp_data` this cycle |
| rsp_data | output | LINE_BYTES*8 | Load data broadcast |

## Verification
The bench aims at cases where merging must be selective. In one, all twelve slots target one line and every one must be granted at once; a merger that serves a single request would grant one slot per cycle instead. In another, loads and stores share a line, and only the leader's kind may be granted; a design that ignores the flag would issue a read and a write in one access. Overlapping store masks check that the highest slot's bytes win, which catches a wrong scan order or a missing overwrite. A run where every slot targets a different line checks that the pointer visits each slot once in twelve cycles; a pointer that does not advance would starve the later slots. Random traffic on three lines, scored against a reference model that rescans every pending slot, catches a slot that is granted twice in a row and load data that is routed to the wrong slots.

// File: rtl/slm_pkg.sv
package slm_pkg;
  localparam int LANE_W = 8;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } op_e;
endpackage

// File: rtl/slm_rr_leader.sv
module slm_rr_leader #(
  parameter int NREQ  = 12,
  parameter int IDX_W = 4
) (
  input  logic [NREQ-1:0]  elig,
  input  logic [IDX_W-1:0] ptr,
  output logic             found,
  output logic [IDX_W-1:0] lead
);
  logic [IDX_W:0] pos;

  // Scan upward from the pointer, wrapping once around the slots.
  always_comb begin
    found = 1'b0;
    lead  = '0;
    pos   = '0;
    for (int k = 0; k < NREQ; k++) begin
      pos = {1'b0, ptr} + (IDX_W+1)'(k);
      if (pos >= (IDX_W+1)'(NREQ)) pos = pos - (IDX_W+1)'(NREQ);
      if (!found && elig[pos[IDX_W-1:0]]) begin
        found = 1'b1;
        lead  = pos[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/slm_line_matcher.sv
module slm_line_matcher
  import slm_pkg::*;
#(
  parameter int NREQ       = 12,
  parameter int IDX_W      = 4,
  parameter int LINE_AW    = 28,
  parameter int LINE_BYTES = 16,
  localparam int DATA_W    = LINE_BYTES * LANE_W
) (
  input  logic [NREQ-1:0]       elig,
  input  logic [NREQ-1:0]       is_store,
  input  logic [LINE_AW-1:0]    line_a [NREQ],
  input  logic [LINE_BYTES-1:0] mask_a [NREQ],
  input  logic [DATA_W-1:0]     wd_a   [NREQ],
  input  logic                  found,
  input  logic [IDX_W-1:0]      lead,
  output logic [NREQ-1:0]       match,
  output logic [LINE_AW-1:0]    lead_line,
  output logic                  lead_store,
  output logic [LINE_BYTES-1:0] merged_mask,
  output logic [DATA_W-1:0]     merged_data
);
  op_e lead_op;

  assign lead_line  = line_a[lead];
  assign lead_op    = op_e'(is_store[lead]);
  assign lead_store = (lead_op == OP_STORE);

  for (genvar g = 0; g < NREQ; g++) begin : g_cmp
    assign match[g] = found && elig[g] && (line_a[g] == lead_line)
                      && (op_e'(is_store[g]) == lead_op);
  end

  // Ascending scan: a higher slot overwrites a shared byte lane.
  always_comb begin
    merged_mask = '0;
    merged_data = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (match[i]) begin
        merged_mask = merged_mask | mask_a[i];
        for (int b = 0; b < LINE_BYTES; b++) begin
          if (mask_a[i][b]) merged_data[b*LANE_W +: LANE_W] = wd_a[i][b*LANE_W +: LANE_W];
        end
      end
    end
  end
endmodule

// File: rtl/same_line_merger.sv
module same_line_merger
  import slm_pkg::*;
#(
  parameter int UNITS      = 6,
  parameter int PORTS      = 2,
  parameter int LINE_AW    = 28,
  parameter int LINE_BYTES = 16,
  localparam int NREQ      = UNITS * PORTS,
  localparam int IDX_W     = (NREQ > 1) ? $clog2(NREQ) : 1,
  localparam int DATA_W    = LINE_BYTES * LANE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NREQ-1:0]            req_valid,
  input  logic [NREQ-1:0]            req_store,
  input  logic [NREQ*LINE_AW-1:0]    req_line,
  input  logic [NREQ*LINE_BYTES-1:0] req_mask,
  input  logic [NREQ*DATA_W-1:0]     req_wdata,
  output logic                       l1_valid,
  output logic                       l1_store,
  output logic [LINE_AW-1:0]         l1_line,
  output logic [LINE_BYTES-1:0]      l1_mask,
  output logic [DATA_W-1:0]          l1_wdata,
  input  logic [DATA_W-1:0]          l1_rdata,
  input  logic                       l1_rvalid,
  output logic [NREQ-1:0]            grant,
  output logic [NREQ-1:0]            rsp_valid,
  output logic [DATA_W-1:0]          rsp_data
);
  logic [LINE_AW-1:0]    line_a [NREQ];
  logic [LINE_BYTES-1:0] mask_a [NREQ];
  logic [DATA_W-1:0]     wd_a   [NREQ];

  for (genvar g = 0; g < NREQ; g++) begin : g_unpack
    assign line_a[g] = req_line[g*LINE_AW +: LINE_AW];
    assign mask_a[g] = req_mask[g*LINE_BYTES +: LINE_BYTES];
    assign wd_a[g]   = req_wdata[g*DATA_W +: DATA_W];
  end

  logic [NREQ-1:0]       grant_q, own_q, elig, match;
  logic [IDX_W-1:0]      ptr_q, lead;
  logic                  found, lead_store;
  logic [LINE_AW-1:0]    lead_line;
  logic [LINE_BYTES-1:0] merged_mask;
  logic [DATA_W-1:0]     merged_data;

  // A slot whose grant is on show this cycle may already hold a new request.
  assign elig = req_valid & ~grant_q;

  slm_rr_leader #(.NREQ(NREQ), .IDX_W(IDX_W)) u_leader (
    .elig  (elig),
    .ptr   (ptr_q),
    .found (found),
    .lead  (lead)
  );

  slm_line_matcher #(
    .NREQ(NREQ), .IDX_W(IDX_W), .LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES)
  ) u_match (
    .elig        (elig),
    .is_store    (req_store),
    .line_a      (line_a),
    .mask_a      (mask_a),
    .wd_a        (wd_a),
    .found       (found),
    .lead        (lead),
    .match       (match),
    .lead_line   (lead_line),
    .lead_store  (lead_store),
    .merged_mask (merged_mask),
    .merged_data (merged_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q  <= '0;
      own_q    <= '0;
      ptr_q    <= '0;
      l1_valid <= 1'b0;
      l1_store <= 1'b0;
      l1_line  <= '0;
      l1_mask  <= '0;
      l1_wdata <= '0;
    end else begin
      grant_q  <= match;
      l1_valid <= found;
      l1_store <= found && lead_store;
      l1_line  <= found ? lead_line : '0;
      l1_mask  <= merged_mask;
      l1_wdata <= merged_data;
      own_q    <= (l1_valid && !l1_store) ? grant_q : '0;
      if (found) ptr_q <= (lead == IDX_W'(NREQ-1)) ? '0 : lead + IDX_W'(1);
    end
  end

  assign grant     = grant_q;
  assign rsp_valid = l1_rvalid ? own_q : '0;
  assign rsp_data  = l1_rdata;
endmodule

// File: rtl/slm_checker.sv
module slm_checker #(
  parameter int NREQ       = 12,
  parameter int LINE_AW    = 28,
  parameter int LINE_BYTES = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NREQ-1:0]            req_valid,
  input logic [NREQ*LINE_AW-1:0]    req_line,
  input logic [NREQ*LINE_BYTES-1:0] req_mask,
  input logic                       l1_valid,
  input logic                       l1_store,
  input logic [LINE_AW-1:0]         l1_line,
  input logic [LINE_BYTES-1:0]      l1_mask,
  input logic [NREQ-1:0]            grant,
  input logic [NREQ-1:0]            rsp_valid
);
  logic [NREQ-1:0]            prev_valid, prev_grant;
  logic [NREQ*LINE_AW-1:0]    prev_line;
  logic [NREQ*LINE_BYTES-1:0] prev_mask;
  logic                       prev_ld;
  logic [LINE_AW-1:0]         pl [NREQ];
  logic [LINE_BYTES-1:0]      pm [NREQ];
  logic [LINE_BYTES-1:0]      exp_or;
  logic                       line_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid <= '0;
      prev_grant <= '0;
      prev_line  <= '0;
      prev_mask  <= '0;
      prev_ld    <= 1'b0;
    end else begin
      prev_valid <= req_valid;
      prev_grant <= grant;
      prev_line  <= req_line;
      prev_mask  <= req_mask;
      prev_ld    <= l1_valid && !l1_store;
    end
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_prev
    assign pl[g] = prev_line[g*LINE_AW +: LINE_AW];
    assign pm[g] = prev_mask[g*LINE_BYTES +: LINE_BYTES];
  end

  always_comb begin
    exp_or  = '0;
    line_ok = 1'b1;
    for (int i = 0; i < NREQ; i++) begin
      if (grant[i]) begin
        exp_or = exp_or | pm[i];
        if (pl[i] != l1_line) line_ok = 1'b0;
      end
    end
  end

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst) (grant & prev_grant) == '0); // R7
  AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) (grant & ~prev_valid) == '0); // R3
  AST_SAME_LINE: assert property (@(posedge clk) disable iff (rst) l1_valid |-> line_ok); // R3
  AST_MASK_UNION: assert property (@(posedge clk) disable iff (rst) l1_valid |-> (l1_mask == exp_or)); // R4
  AST_ACCESS_WITH_GRANT: assert property (@(posedge clk) disable iff (rst) l1_valid == (grant != '0)); // R6
  AST_RSP_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst) (rsp_valid != '0) |-> prev_ld); // R8
  AST_RSP_SUBSET: assert property (@(posedge clk) disable iff (rst) (rsp_valid & ~prev_grant) == '0); // R8
endmodule

bind same_line_merger slm_checker #(
  .NREQ(NREQ), .LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES)
) u_slm_checker (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_line  (req_line),
  .req_mask  (req_mask),
  .l1_valid  (l1_valid),
  .l1_store  (l1_store),
  .l1_line   (l1_line),
  .l1_mask   (l1_mask),
  .grant     (grant),
  .rsp_valid (rsp_valid)
);

// File: tb/same_line_merger_test.sv
module same_line_merger_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 12;
  localparam int AW   = 28;
  localparam int NB   = 16;
  localparam int DW   = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NREQ-1:0] req_valid, req_store, grant, rsp_valid;
  logic [NREQ*AW-1:0] req_line;
  logic [NREQ*NB-1:0] req_mask;
  logic [NREQ*DW-1:0] req_wdata;
  logic l1_valid, l1_store, l1_rvalid;
  logic [AW-1:0] l1_line;
  logic [NB-1:0] l1_mask;
  logic [DW-1:0] l1_wdata, l1_rdata, rsp_data;

  same_line_merger uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_line(req_line), .req_mask(req_mask), .req_wdata(req_wdata),
    .l1_valid(l1_valid), .l1_store(l1_store), .l1_line(l1_line),
    .l1_mask(l1_mask), .l1_wdata(l1_wdata), .l1_rdata(l1_rdata),
    .l1_rvalid(l1_rvalid), .grant(grant), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic          v  [NREQ];
  logic          s  [NREQ];
  logic [AW-1:0] ln [NREQ];
  logic [NB-1:0] mk [NREQ];
  logic [DW-1:0] wd [NREQ];

  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      req_valid[i] = v[i];
      req_store[i] = s[i];
      req_line[i*AW +: AW]  = ln[i];
      req_mask[i*NB +: NB]  = mk[i];
      req_wdata[i*DW +: DW] = wd[i];
    end
  end

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int ptr_m = 0;
  int last_pat = 0;
  logic [NREQ-1:0] exp_grant, shown, due_grant, acc;
  logic exp_valid, exp_store, due;
  logic [AW-1:0] exp_line;
  logic [NB-1:0] exp_mask;
  logic [DW-1:0] exp_wdata, rd_pat;

  task automatic cmp(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rand128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Reference: rescan every pending slot from the model pointer.
  task automatic model();
    logic [NREQ-1:0] el;
    int lead;
    bit fnd;
    fnd = 1'b0; lead = 0;
    exp_grant = '0; exp_mask = '0; exp_wdata = '0; exp_line = '0; exp_store = 1'b0;
    for (int i = 0; i < NREQ; i++) el[i] = v[i] && !shown[i];
    for (int k = 0; k < NREQ; k++) begin
      int idx = (ptr_m + k) % NREQ;
      if (!fnd && el[idx]) begin fnd = 1'b1; lead = idx; end
    end
    exp_valid = fnd;
    if (fnd) begin
      exp_line = ln[lead];
      exp_store = s[lead];
      for (int i = 0; i < NREQ; i++) begin
        if (el[i] && ln[i] == ln[lead] && s[i] == s[lead]) begin
          exp_grant[i] = 1'b1;
          exp_mask = exp_mask | mk[i];
          for (int b = 0; b < NB; b++)
            if (mk[i][b]) exp_wdata[b*8 +: 8] = wd[i][b*8 +: 8];
        end
      end
      ptr_m = (lead + 1) % NREQ;
    end
  endtask

  task automatic fill(input int pat);
    case (pat)
      0: for (int i = 0; i < NREQ; i++) v[i] = 1'b0;
      1: for (int i = 0; i < NREQ; i++) begin
           v[i] = 1'b1; s[i] = 1'b0; ln[i] = 28'd5; mk[i] = 16'(1 << i); wd[i] = rand128();
         end
      2: begin
           for (int i = 0; i < NREQ; i++) v[i] = 1'b0;
           foreach (ln[i]) begin ln[i] = 28'd7; s[i] = 1'b1; wd[i] = {16{8'(i)}}; end
           v[2] = 1'b1; mk[2] = 16'h00FF;
           v[5] = 1'b1; mk[5] = 16'h0F0F;
           v[9] = 1'b1; mk[9] = 16'h0003;
         end
      3: for (int i = 0; i < NREQ; i++) begin
           v[i] = 1'b1; s[i] = i[0]; ln[i] = 28'd3; mk[i] = 16'($urandom); wd[i] = rand128();
         end
      4: for (int i = 0; i < NREQ; i++) begin
           v[i] = 1'b1; s[i] = 1'b0; ln[i] = 28'(100 + i); mk[i] = 16'hFFFF; wd[i] = rand128();
         end
      5: for (int i = 0; i < NREQ; i++) if (v[i] && shown[i]) v[i] = 1'b0;
      default: for (int i = 0; i < NREQ; i++) begin
           if (!v[i] || shown[i]) begin
             if ($urandom % 3 != 0) begin
               v[i] = 1'b1; s[i] = 1'($urandom % 2); ln[i] = 28'($urandom % 3);
               mk[i] = 16'($urandom); wd[i] = rand128();
             end else v[i] = 1'b0;
           end
         end
    endcase
  endtask

  task automatic cycle(input int pat);
    @(negedge clk);
    if (due) begin
      rd_pat = rand128();
      l1_rdata = rd_pat; l1_rvalid = 1'b1;
      #1;
      cmp("R8 load slots", DW'(rsp_valid), DW'(due_grant));
      cmp("R8 load data", rsp_data, rd_pat);
    end else begin
      l1_rvalid = 1'b0;
      #1;
      cmp("R8 no response", DW'(rsp_valid), '0);
    end
    cmp("R2 R3 grant", DW'(grant), DW'(exp_grant));
    cmp("R6 access valid", DW'(l1_valid), DW'(exp_valid));
    cmp("R4 line", DW'(l1_line), DW'(exp_line));
    cmp("R4 store flag", DW'(l1_store), DW'(exp_store));
    cmp("R4 mask", DW'(l1_mask), DW'(exp_mask));
    cmp("R5 wdata", l1_wdata, exp_wdata);
    if (!exp_valid) cmp("R9 idle access", DW'({l1_valid, l1_mask, grant}), '0);
    case (last_pat)
      1: begin
           cmp("R3 all same-line slots", DW'(grant), DW'(12'hFFF));
           cmp("R4 merged mask", DW'(l1_mask), DW'(16'h0FFF));
         end
      2: begin
           cmp("R5 byte0 youngest", DW'(l1_wdata[7:0]), DW'(8'd9));
           cmp("R5 byte4", DW'(l1_wdata[39:32]), DW'(8'd2));
           cmp("R5 byte8", DW'(l1_wdata[71:64]), DW'(8'd5));
           cmp("R5 unwritten byte12", DW'(l1_wdata[103:96]), '0);
         end
      3: cmp("R3 one op type", DW'((grant == 12'h555 && !l1_store) || (grant == 12'hAAA && l1_store)), DW'(1));
      4, 5: begin
           cmp("R2 one slot per line", DW'($countones(grant)), DW'(1));
           acc = acc | grant;
         end
      default: ;
    endcase
    due = l1_valid && !l1_store;
    due_grant = grant;
    shown = exp_grant;
    fill(pat);
    model();
    last_pat = pat;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd4242);
    l1_rvalid = 1'b0; l1_rdata = '0;
    for (int i = 0; i < NREQ; i++) begin
      v[i] = 1'b0; s[i] = 1'b0; ln[i] = '0; mk[i] = '0; wd[i] = '0;
    end
    exp_grant = '0; shown = '0; due = 1'b0; due_grant = '0; acc = '0;
    exp_valid = 1'b0; exp_store = 1'b0; exp_line = '0; exp_mask = '0; exp_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1 reset access", DW'({l1_valid, l1_store, l1_line, l1_mask}), '0);
    cmp("R1 reset wdata", l1_wdata, '0);
    cmp("R1 reset grant", DW'(grant), '0);
    cmp("R1 reset response", DW'(rsp_valid), '0);
    rst = 1'b0;
    cycle(0); cycle(1); cycle(0); cycle(2); cycle(0); cycle(3); cycle(0);
    cycle(4);
    for (int n = 0; n < 11; n++) cycle(5);
    cycle(0);
    cmp("R2 every slot served once", DW'(acc), DW'(12'hFFF));
    for (int n = 0; n < 1500; n++) cycle(6);
    cycle(0); cycle(0); cycle(0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule